// File: doc/BRIEF.md
# Synchronized Timestamp Clock Supervisor

This block keeps a time-of-day clock with one-millisecond resolution and a day count. It advances on an external millisecond tick. A separate supervisor measures how long it has been since the clock last accepted a valid time reference. A valid, plausible sync message loads a new day and millisecond value and restarts that measurement. A message flagged as bad, or one whose millisecond field is out of range, is dropped. The clock then keeps running on its own and the age measurement continues.

Two limits apply to the age measurement:
- After ten minutes without a reference, the reference-error flag rises.
- Once the programmed validity reserve (in hours) has run out, the time-invalid flag rises.

A reserve of zero selects free-running operation. In that mode only the not-synchronized flag is shown. An event strobe latches the current {day, ms} into a timestamp register. If the time was invalid at that moment, the top byte of the millisecond field is forced to 0xFF.

The supervisor is a four-state machine:
- FREE_RUN: the reserve is zero.
- TRACKING: the reference is fresh.
- REF_LOST: ten or more minutes have passed without a reference.
- TIME_INVALID: the reserve has been exceeded.

The transitions are:
- Any state enters FREE_RUN whenever the reserve is zero.
- Any state returns to TRACKING on an accepted sync.
- FREE_RUN goes to TRACKING when a nonzero reserve is programmed.
- TRACKING goes to REF_LOST when the age reaches ten minutes.
- TRACKING or REF_LOST goes to TIME_INVALID when the age reaches the reserve.
- TIME_INVALID is held until a sync is accepted or the reserve drops to zero.

Top module: `tsclk_supervisor`

## Requirements
- R1: After reset the clock reads day 0, ms 0 (midnight, 1 Jan 1990), runs on ticks without waiting for a sync, and with a nonzero reserve the status word is 0x00.
- R2: Each ms_tick adds one to the millisecond count. From 86,399,999 it wraps to 0 and the day count increments.
- R3: A sync is accepted when sync_valid=1, sync_bad=0 and sync_ms<86,400,000. It loads sync_day/sync_ms, visible from the next cycle, and restarts both age timers.
- R4: Status bit 2 (reference error) is set once 10 minutes (10×TICKS_PER_MIN ticks) have passed since the last accepted sync or reset. It is clear before that.
- R5: Status bit 3 (time invalid) is set once the reserve (hours × 60 minutes) has passed without an accepted sync. Bit 3 is never set without bit 2.
- R6: An evt_strobe latches the current day into ts_day and the zero-extended ms into ts_ms. ts_valid is high exactly on the next cycle only.
- R7: If status bit 3 was set when the strobe was captured, ts_ms[31:24] is 0xFF and ts_ms[23:0] holds the true millisecond bits.
- R8: An accepted sync clears status bits 2 and 3 by the next cycle.
- R9: A sync with sync_bad=1, or with sync_ms out of range, neither loads the clock nor restarts the age timers.
- R10: A reserve of 0 selects free-running mode. Status bit 4 is set, bits 2 and 3 stay clear, and the age timers are held at zero, so a later nonzero reserve starts a fresh measurement.
- R11: With radio_mode=1, reserve settings above 5 act as 5 hours. With radio_mode=0, settings above 254 act as 254 hours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| sync_valid | input | 1 | Sync message strobe |
| sync_bad | input | 1 | Marks the current sync message as implausible |
| sync_day | input | 16 | Day number carried by the sync message |
| sync_ms | input | 27 | Millisecond of day carried by the sync message |
| radio_mode | input | 1 | 1: radio reference (reserve 1..5 h), 0: master message (1..254 h) |
| reserve_hours | input | 8 | Validity reserve in hours, 0 = free-running |
| evt_strobe | input | 1 | Capture a timestamp |
| status | output | 8 | Bit 2 reference error, bit 3 time invalid, bit 4 not synchronized, others 0 |
| ts_day | output | 16 | Captured day |
| ts_ms | output | 32 | Captured millisecond field, top byte 0xFF when invalid |
| ts_valid | output | 1 | High the cycle after a capture |

## Verification
The assertions check the flag relationships on every cycle:
- Free-running mode excludes the error flags.
- The time-invalid flag implies the reference-error flag.
- An accepted sync clears both flags on the next cycle.
- ts_valid follows evt_strobe by exactly one cycle.
- The 0xFF marking matches the status seen at capture.

Only the bench scenarios can show the rest:
- the exact tick counts at which each flag rises;
- the loaded and rolled-over clock values;
- that rejected messages leave both the clock and the age measurement untouched;
- the radio-mode reserve clamp.

// File: rtl/tsclk_pkg.sv
package tsclk_pkg;

    typedef enum logic [1:0] {
        ST_FREE_RUN     = 2'd0,
        ST_TRACKING     = 2'd1,
        ST_REF_LOST     = 2'd2,
        ST_TIME_INVALID = 2'd3
    } sup_state_e;

    localparam int STAT_W            = 8;
    localparam int STAT_REF_ERR_BIT  = 2;
    localparam int STAT_TIME_INV_BIT = 3;
    localparam int STAT_UNSYNC_BIT   = 4;
    localparam int MIN_PER_HOUR      = 60;

endpackage

// File: rtl/tsclk_tod.sv
module tsclk_tod #(
    parameter int MS_PER_DAY = 86_400_000,
    parameter int MS_W       = 27,
    parameter int DAY_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             load,
    input  logic [DAY_W-1:0] load_day,
    input  logic [MS_W-1:0]  load_ms,
    output logic [DAY_W-1:0] day,
    output logic [MS_W-1:0]  ms
);

    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_DAY - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            day <= '0;
            ms  <= '0;
        end else if (load) begin
            day <= load_day;
            ms  <= load_ms;
        end else if (ms_tick) begin
            if (ms == MS_LAST) begin
                ms  <= '0;
                day <= day + 1'b1;
            end else begin
                ms  <= ms + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tsclk_age_timer.sv
module tsclk_age_timer #(
    parameter int TICKS_PER_MIN = 60_000,
    parameter int MIN_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             clear,
    output logic [MIN_W-1:0] elapsed_min
);

    localparam logic [MIN_W-1:0] MIN_SAT = '1;

    logic minute_done;

    generate
        if (TICKS_PER_MIN > 1) begin : g_presc
            localparam int            PW     = $clog2(TICKS_PER_MIN);
            localparam logic [PW-1:0] P_LAST = PW'(TICKS_PER_MIN - 1);
            logic [PW-1:0] pcnt;

            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    pcnt <= '0;
                end else if (ms_tick) begin
                    pcnt <= (pcnt == P_LAST) ? '0 : pcnt + 1'b1;
                end
            end

            assign minute_done = ms_tick && (pcnt == P_LAST);
        end else begin : g_direct
            assign minute_done = ms_tick;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            elapsed_min <= '0;
        end else if (minute_done && (elapsed_min != MIN_SAT)) begin
            elapsed_min <= elapsed_min + 1'b1;
        end
    end

endmodule

// File: rtl/tsclk_sup_fsm.sv
module tsclk_sup_fsm
    import tsclk_pkg::*;
#(
    parameter int RES_W        = 8,
    parameter int MIN_W        = 16,
    parameter int REF_ERR_MIN  = 10,
    parameter int RADIO_MAX_H  = 5,
    parameter int MASTER_MAX_H = 254
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] reserve_hours,
    input  logic             radio_mode,
    input  logic             sync_accept,
    input  logic [MIN_W-1:0] elapsed_min,
    output logic             timer_clear,
    output logic             flag_ref_err,
    output logic             flag_time_inv,
    output logic             flag_unsync
);

    localparam logic [RES_W-1:0] RADIO_MAX  = RES_W'(RADIO_MAX_H);
    localparam logic [RES_W-1:0] MASTER_MAX = RES_W'(MASTER_MAX_H);
    localparam logic [MIN_W-1:0] REF_LIM    = MIN_W'(REF_ERR_MIN);

    sup_state_e       state, state_nxt;
    logic [RES_W-1:0] eff_hours;
    logic [MIN_W-1:0] res_min;
    logic             free_sel;
    logic             reserve_gone;
    logic             ref_gone;

    always_comb begin
        if (radio_mode && (reserve_hours > RADIO_MAX)) begin
            eff_hours = RADIO_MAX;
        end else if (reserve_hours > MASTER_MAX) begin
            eff_hours = MASTER_MAX;
        end else begin
            eff_hours = reserve_hours;
        end
    end

    assign res_min      = MIN_W'(eff_hours) * MIN_W'(MIN_PER_HOUR);
    assign free_sel     = (reserve_hours == '0);
    assign reserve_gone = (elapsed_min >= res_min);
    assign ref_gone     = (elapsed_min >= REF_LIM);
    assign timer_clear  = sync_accept || free_sel;

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (free_sel) begin
            state_nxt = ST_FREE_RUN;
        end else if (sync_accept) begin
            state_nxt = ST_TRACKING;
        end else begin
            unique case (state)
                ST_FREE_RUN:     state_nxt = ST_TRACKING;
                ST_TRACKING: begin
                    if (reserve_gone)  state_nxt = ST_TIME_INVALID;
                    else if (ref_gone) state_nxt = ST_REF_LOST;
                end
                ST_REF_LOST: begin
                    if (reserve_gone)  state_nxt = ST_TIME_INVALID;
                end
                ST_TIME_INVALID: state_nxt = ST_TIME_INVALID;
                default:         state_nxt = ST_TRACKING;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_TRACKING;
        end else begin
            state <= state_nxt;
        end
    end

    // output decode
    always_comb begin
        flag_ref_err  = 1'b0;
        flag_time_inv = 1'b0;
        flag_unsync   = 1'b0;
        unique case (state)
            ST_FREE_RUN:     flag_unsync = 1'b1;
            ST_TRACKING:     ;
            ST_REF_LOST:     flag_ref_err = 1'b1;
            ST_TIME_INVALID: begin
                flag_ref_err  = 1'b1;
                flag_time_inv = 1'b1;
            end
            default:         ;
        endcase
    end

endmodule

// File: rtl/tsclk_capture.sv
module tsclk_capture #(
    parameter int DAY_W   = 16,
    parameter int MS_W    = 27,
    parameter int TS_MS_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_strobe,
    input  logic               force_ff,
    input  logic [DAY_W-1:0]   day,
    input  logic [MS_W-1:0]    ms,
    output logic [DAY_W-1:0]   ts_day,
    output logic [TS_MS_W-1:0] ts_ms,
    output logic               ts_valid
);

    localparam int LOW_W = TS_MS_W - 8;

    logic [TS_MS_W-1:0] ms_wide;
    logic [TS_MS_W-1:0] stamp;

    assign ms_wide = TS_MS_W'(ms);
    assign stamp   = force_ff ? {8'hFF, ms_wide[LOW_W-1:0]} : ms_wide;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_day   <= '0;
            ts_ms    <= '0;
            ts_valid <= 1'b0;
        end else begin
            ts_valid <= evt_strobe;
            if (evt_strobe) begin
                ts_day <= day;
                ts_ms  <= stamp;
            end
        end
    end

endmodule

// File: rtl/tsclk_supervisor.sv
module tsclk_supervisor
    import tsclk_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60_000,
    parameter int MS_PER_DAY    = 86_400_000,
    parameter int MS_W          = 27,
    parameter int DAY_W         = 16,
    parameter int RES_W         = 8,
    parameter int TS_MS_W       = 32,
    parameter int MIN_W         = 16,
    parameter int REF_ERR_MIN   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ms_tick,
    input  logic               sync_valid,
    input  logic               sync_bad,
    input  logic [DAY_W-1:0]   sync_day,
    input  logic [MS_W-1:0]    sync_ms,
    input  logic               radio_mode,
    input  logic [RES_W-1:0]   reserve_hours,
    input  logic               evt_strobe,
    output logic [STAT_W-1:0]  status,
    output logic [DAY_W-1:0]   ts_day,
    output logic [TS_MS_W-1:0] ts_ms,
    output logic               ts_valid
);

    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_DAY - 1);

    logic             sync_accept;
    logic             timer_clear;
    logic [MIN_W-1:0] elapsed_min;
    logic [DAY_W-1:0] cur_day;
    logic [MS_W-1:0]  cur_ms;
    logic             flag_ref_err, flag_time_inv, flag_unsync;

    assign sync_accept = sync_valid && !sync_bad && (sync_ms <= MS_LAST);

    tsclk_tod #(
        .MS_PER_DAY (MS_PER_DAY),
        .MS_W       (MS_W),
        .DAY_W      (DAY_W)
    ) tod_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .load     (sync_accept),
        .load_day (sync_day),
        .load_ms  (sync_ms),
        .day      (cur_day),
        .ms       (cur_ms)
    );

    tsclk_age_timer #(
        .TICKS_PER_MIN (TICKS_PER_MIN),
        .MIN_W         (MIN_W)
    ) age_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ms_tick     (ms_tick),
        .clear       (timer_clear),
        .elapsed_min (elapsed_min)
    );

    tsclk_sup_fsm #(
        .RES_W       (RES_W),
        .MIN_W       (MIN_W),
        .REF_ERR_MIN (REF_ERR_MIN)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reserve_hours (reserve_hours),
        .radio_mode    (radio_mode),
        .sync_accept   (sync_accept),
        .elapsed_min   (elapsed_min),
        .timer_clear   (timer_clear),
        .flag_ref_err  (flag_ref_err),
        .flag_time_inv (flag_time_inv),
        .flag_unsync   (flag_unsync)
    );

    tsclk_capture #(
        .DAY_W   (DAY_W),
        .MS_W    (MS_W),
        .TS_MS_W (TS_MS_W)
    ) cap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_strobe (evt_strobe),
        .force_ff   (flag_time_inv),
        .day        (cur_day),
        .ms         (cur_ms),
        .ts_day     (ts_day),
        .ts_ms      (ts_ms),
        .ts_valid   (ts_valid)
    );

    always_comb begin
        status                    = '0;
        status[STAT_REF_ERR_BIT]  = flag_ref_err;
        status[STAT_TIME_INV_BIT] = flag_time_inv;
        status[STAT_UNSYNC_BIT]   = flag_unsync;
    end

endmodule

// File: rtl/tsclk_supervisor_chk.sv
module tsclk_supervisor_chk #(
    parameter int MS_PER_DAY = 86_400_000,
    parameter int MS_W       = 27,
    parameter int RES_W      = 8,
    parameter int TS_MS_W    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync_valid,
    input logic               sync_bad,
    input logic [MS_W-1:0]    sync_ms,
    input logic [RES_W-1:0]   reserve_hours,
    input logic               evt_strobe,
    input logic [7:0]         status,
    input logic [TS_MS_W-1:0] ts_ms,
    input logic               ts_valid
);

    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_DAY - 1);

    logic accepted;
    assign accepted = sync_valid && !sync_bad && (sync_ms <= MS_LAST);

    p_free_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] |-> (status[3:2] == 2'b00));

    p_free_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reserve_hours == '0) |=> status[4]);

    p_inv_implies_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] |-> status[2]);

    p_sync_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> (status[3:2] == 2'b00));

    p_ts_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_strobe |=> ts_valid);

    p_ts_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_strobe |=> !ts_valid);

    p_ts_marked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && $past(status[3])) |-> (ts_ms[TS_MS_W-1 -: 8] == 8'hFF));

    p_ts_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && !$past(status[3])) |-> (ts_ms[TS_MS_W-1 -: 8] != 8'hFF));

endmodule

bind tsclk_supervisor tsclk_supervisor_chk #(
    .MS_PER_DAY (MS_PER_DAY),
    .MS_W       (MS_W),
    .RES_W      (RES_W),
    .TS_MS_W    (TS_MS_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_valid    (sync_valid),
    .sync_bad      (sync_bad),
    .sync_ms       (sync_ms),
    .reserve_hours (reserve_hours),
    .evt_strobe    (evt_strobe),
    .status        (status),
    .ts_ms         (ts_ms),
    .ts_valid      (ts_valid)
);

// File: tb/tsclk_supervisor_tb_top.sv
module tsclk_supervisor_tb_top;

    localparam int TPM      = 20;
    localparam int MS_DAY   = 86_400_000;
    localparam int WATCHDOG = 150_000;

    // table: [39:24] tick count, [23:16] status after, [15:0] unused
    localparam int NVEC = 4;
    localparam logic [39:0] VEC [NVEC] = '{
        {16'd199, 8'h00, 16'h0},   // R4: one tick short of 10 min
        {16'd1,   8'h04, 16'h0},   // R4: 10 min reached
        {16'd999, 8'h04, 16'h0},   // R5: one tick short of 1 h
        {16'd1,   8'h0C, 16'h0}    // R5: reserve exhausted
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        sync_valid = 1'b0;
    logic        sync_bad = 1'b0;
    logic [15:0] sync_day = '0;
    logic [26:0] sync_ms = '0;
    logic        radio_mode = 1'b0;
    logic [7:0]  reserve_hours = 8'd1;
    logic        evt_strobe = 1'b0;
    logic [7:0]  status;
    logic [15:0] ts_day;
    logic [31:0] ts_ms;
    logic        ts_valid;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    tsclk_supervisor #(.TICKS_PER_MIN(TPM)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ms_tick       (ms_tick),
        .sync_valid    (sync_valid),
        .sync_bad      (sync_bad),
        .sync_day      (sync_day),
        .sync_ms       (sync_ms),
        .radio_mode    (radio_mode),
        .reserve_hours (reserve_hours),
        .evt_strobe    (evt_strobe),
        .status        (status),
        .ts_day        (ts_day),
        .ts_ms         (ts_ms),
        .ts_valid      (ts_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        ms_tick = 1'b1;
        repeat (n) @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic send_sync(input logic [15:0] d, input logic [26:0] m, input logic bad);
        @(negedge clk);
        sync_valid = 1'b1;
        sync_bad   = bad;
        sync_day   = d;
        sync_ms    = m;
        @(negedge clk);
        sync_valid = 1'b0;
        sync_bad   = 1'b0;
    endtask

    task automatic capture(input string req, input logic [15:0] exp_day, input logic [31:0] exp_ms);
        @(negedge clk);
        evt_strobe = 1'b1;
        @(negedge clk);
        evt_strobe = 1'b0;
        check({req, " ts_valid"}, 64'(ts_valid), 64'd1);
        check({req, " ts_day"}, 64'(ts_day), 64'(exp_day));
        check({req, " ts_ms"}, 64'(ts_ms), 64'(exp_ms));
        @(negedge clk);
        check({req, " ts_valid drop"}, 64'(ts_valid), 64'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        check("R1 status after reset", 64'(status), 64'h00);
        capture("R1 reset clock", 16'd0, 32'd0);

        // R1, R2: free run from reset, no sync needed
        run_ticks(5);
        capture("R2 ticks count", 16'd0, 32'd5);

        // R3: sync load
        send_sync(16'd5, 27'd1000, 1'b0);
        run_ticks(3);
        capture("R3 load", 16'd5, 32'd1003);

        // R2: day rollover
        send_sync(16'd7, 27'(MS_DAY - 2), 1'b0);
        run_ticks(3);
        capture("R2 rollover", 16'd8, 32'd1);

        // R4, R5: vector table from a fresh sync, reserve 1 h master mode
        reserve_hours = 8'd1;
        send_sync(16'd1, 27'd5000, 1'b0);
        for (int i = 0; i < NVEC; i++) begin
            run_ticks(int'(VEC[i][39:24]));
            idle(2);
            check($sformatf("R4/R5 vector %0d status", i), 64'(status), 64'(VEC[i][23:16]));
        end

        // R7: capture while invalid
        capture("R7 marked stamp", 16'd1, {8'hFF, 24'd6200});

        // R8: valid sync clears bits 2 and 3
        send_sync(16'd3, 27'd0, 1'b0);
        idle(1);
        check("R8 flags cleared", 64'(status), 64'h00);
        capture("R8 clean stamp", 16'd3, 32'd0);

        // R9: implausible sync neither loads nor restarts timers
        send_sync(16'd2, 27'd100, 1'b0);
        run_ticks(150);
        send_sync(16'd9, 27'd50000, 1'b1);
        run_ticks(50);
        idle(2);
        check("R9 bad sync keeps age", 64'(status), 64'h04);
        capture("R9 bad sync no load", 16'd2, 32'd300);

        // R9: out-of-range ms rejected
        send_sync(16'd11, 27'(MS_DAY), 1'b0);
        idle(2);
        check("R9 range reject keeps flag", 64'(status), 64'h04);
        capture("R9 range reject no load", 16'd2, 32'd300);

        // R11: radio mode clamps reserve 9 to 5 h
        radio_mode    = 1'b1;
        reserve_hours = 8'd9;
        send_sync(16'd0, 27'd0, 1'b0);
        run_ticks(5 * 60 * TPM - 1);
        idle(2);
        check("R11 clamp not yet", 64'(status), 64'h04);
        run_ticks(1);
        idle(2);
        check("R11 clamp at 5h", 64'(status), 64'h0C);
        radio_mode = 1'b0;

        // R10: free-running mode
        reserve_hours = 8'd0;
        idle(2);
        check("R10 free flag", 64'(status), 64'h10);
        run_ticks(300);
        idle(2);
        check("R10 no errors when free", 64'(status), 64'h10);
        reserve_hours = 8'd1;
        idle(2);
        check("R10 leave free", 64'(status), 64'h00);
        run_ticks(199);
        idle(2);
        check("R10 fresh age after free", 64'(status), 64'h00);
        run_ticks(1);
        idle(2);
        check("R4 ref error after free", 64'(status), 64'h04);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule